// File: doc/BRIEF.md
# External Event SMI Capture Register

This block samples a set of active-low external event lines and raises a system management interrupt (SMI) request when a line that software has armed goes from high to low. Each line is first brought into the local clock domain through a short flop chain. A high-to-low transition seen after that chain is a qualifying event. Holding a line low, or returning it high, is not an event.

Software reaches a single 32-bit register through a plain read/write strobe port. The low byte holds one arm bit per line, and only this byte can be written. Each captured event appears twice: once in a view that reading does not disturb, and once in a view that a read clears. Both views are backed by one set of sticky flags, so a read clears both together.

The block drives a level SMI request. It also drives a one-bit summary that a higher-level SMI status register can gather. Both stay high while any event flag is pending.

Top module: `ext_evt_smi_capture`

## Requirements
- R1: After reset every arm bit and every event flag is 0, the register reads 0x00000000, and `smi_req_o` and `smi_sum_o` are low.
- R2: A write loads `reg_wdata_i[7:0]` into the arm bits. Bit n arms line n, and the register reads back that value in bits 7:0.
- R3: Write data in bits 31:8 has no effect. In particular, writing to either event view neither sets nor clears a flag, and bits 31:24 always read 0.
- R4: When line n is armed and its input goes from 1 to 0, bit 8+n and bit 16+n both read 1. The flag first appears after the third rising clock edge following the input change, and not after the second.
- R5: A high-to-low transition on a line whose arm bit is 0 sets no flag.
- R6: A low-to-high transition sets no flag. A line held low sets no flag, including when it is armed while already low.
- R7: A read returns the flag values from before the clear. All flags read 0 from the next clock onward, while the arm bits are kept.
- R8: An event detected in the same cycle as a clearing read stays set after that read.
- R9: `smi_req_o` and `smi_sum_o` are high exactly while at least one event flag is set, and they fall once a read has cleared all flags.
- R10: A flag stays set after its line returns high, and it remains set through any number of clock cycles and writes until a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_n_i | input | NUM_IN (8) | Active-low external event lines, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; clears the event flags |
| reg_wdata_i | input | 32 | Write data; only bits 7:0 are used |
| reg_rdata_o | output | 32 | Register contents: arm bits 7:0, non-clearing view 15:8, clearing view 23:16 |
| smi_req_o | output | 1 | Level SMI request |
| smi_sum_o | output | 1 | Summary bit for a higher-level SMI status register |

## Verification
The bench builds the block with its defaults: eight lines and a two-flop synchronizer. With only eight lines, all 256 arm masks can be swept. In each pass every line falls at once, so every armed and disarmed combination is checked against the mask in both views, and both the second-edge and third-edge latency points are sampled. Directed cases then target the exact cycle in which a detected event meets a clearing read, lines held low while being armed, and writes that land while flags are pending.

// File: rtl/evt_smi_pkg.sv
package evt_smi_pkg;
    // register geometry; field placement is decoded by software
    localparam int REG_W    = 32;
    localparam int FIELD_W  = 8;
    localparam int ARM_LSB  = 0;
    localparam int VIEW_LSB = 8;
    localparam int CLR_LSB  = 16;
    localparam int RSVD_LSB = 24;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
    parameter int NUM_IN      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] evt_n_i,
    output logic [NUM_IN-1:0] fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_IN-1:0] pipe;
        logic [NUM_IN-1:0]                  prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = evt_n_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev = st_q.pipe[LAST];
    end

    // lines idle high, so reset to 1 to avoid a false edge after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IN; gi++) begin : g_edge
            assign fall_o[gi] = st_q.prev[gi] & ~st_q.pipe[LAST][gi];

            // a detected edge is a single-cycle pulse
            p_fall_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
                fall_o[gi] |=> !fall_o[gi]);
        end
    endgenerate
endmodule

// File: rtl/evt_flag_store.sv
module evt_flag_store #(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] fall_i,
    input  logic [NUM_IN-1:0] arm_i,
    input  logic              clr_i,
    output logic [NUM_IN-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_IN-1:0] flags;
    } store_t;

    store_t st_d, st_q;
    logic [NUM_IN-1:0] hit;

    always_comb begin
        st_d = st_q;
        hit  = fall_i & arm_i;
        if (clr_i) begin
            st_d.flags = '0;
        end
        // a fresh event wins over a clear in the same cycle
        st_d.flags = st_d.flags | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    p_no_disarmed_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(arm_i & fall_i)) == '0));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ((fall_i & arm_i) == '0)) |=> (flags_o == '0));

    p_clear_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flags_o == $past(fall_i & arm_i)));
endmodule

// File: rtl/ext_evt_smi_capture.sv
module ext_evt_smi_capture
    import evt_smi_pkg::*;
#(
    parameter int NUM_IN      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] evt_n_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              smi_req_o,
    output logic              smi_sum_o
);
    typedef struct packed {
        logic [NUM_IN-1:0] arm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NUM_IN-1:0] fall;
    logic [NUM_IN-1:0] flags;
    logic              pending;

    evt_edge_sync #(.NUM_IN(NUM_IN), .SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_n_i (evt_n_i),
        .fall_o  (fall)
    );

    evt_flag_store #(.NUM_IN(NUM_IN)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall),
        .arm_i   (ctl_q.arm),
        .clr_i   (reg_rd_i),
        .flags_o (flags)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr_i) begin
            ctl_d.arm = reg_wdata_i[ARM_LSB +: NUM_IN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        reg_rdata_o[ARM_LSB  +: NUM_IN] = ctl_q.arm;
        reg_rdata_o[VIEW_LSB +: NUM_IN] = flags;
        reg_rdata_o[CLR_LSB  +: NUM_IN] = flags;
    end

    assign pending   = |flags;
    assign smi_req_o = pending;
    assign smi_sum_o = pending;

    initial begin
        p_param_r2: assert (NUM_IN >= 1 && NUM_IN <= FIELD_W && SYNC_STAGES >= 1);
    end

    p_req_matches_view_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req_o == (reg_rdata_o[CLR_LSB +: FIELD_W] != '0));

    p_write_keeps_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_rd_i) |=> ((flags & $past(flags)) == $past(flags)));

    p_arm_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> $stable(reg_rdata_o[ARM_LSB +: NUM_IN]));
endmodule

// File: tb/ext_evt_smi_capture_tb_top.sv
module ext_evt_smi_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] evt_n = '1;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        smi_req, smi_sum;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_evt_smi_capture #(.NUM_IN(N), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_n_i     (evt_n),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .smi_req_o   (smi_req),
        .smi_sum_o   (smi_sum)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] regval(input logic [7:0] arm, input logic [7:0] fl);
        return {8'h00, fl, fl, arm};
    endfunction

    task automatic write_reg(input logic [31:0] v);
        wr = 1'b1; wdata = v;
        tick(1);
        wr = 1'b0; wdata = '0;
    endtask

    // value seen during the read cycle, before the clear lands
    task automatic read_reg(output logic [31:0] v);
        rd = 1'b1;
        #1 v = rdata;
        tick(1);
        rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R1 reset reg", rdata, 32'h0);
        check("R1 reset req", {30'h0, smi_req, smi_sum}, 32'h0);

        write_reg(32'hFFFF_FFFF);
        check("R2 R3 write all ones", rdata, 32'h0000_00FF);
        write_reg(32'h1234_565A);
        check("R2 arm readback", rdata, 32'h0000_005A);

        // full mask sweep, every line falling together
        for (int m = 0; m < 256; m++) begin
            logic [7:0] mk;
            mk = m[7:0];
            write_reg({24'hABCDEF, mk});
            evt_n = '0;
            tick(2);
            check("R4 not before third edge", rdata, regval(mk, 8'h00));
            tick(1);
            check("R4 R5 flags by mask", rdata, regval(mk, mk));
            check("R9 req level", {30'h0, smi_req, smi_sum}, (mk != 0) ? 32'h3 : 32'h0);
            read_reg(v);
            check("R7 read pre-clear", v, regval(mk, mk));
            check("R7 cleared after read", rdata, regval(mk, 8'h00));
            check("R9 req low after clear", {30'h0, smi_req, smi_sum}, 32'h0);
            evt_n = '1;
            tick(4);
            check("R6 rising sets nothing", rdata, regval(mk, 8'h00));
        end

        // stickiness and ignored status writes
        write_reg(32'h0000_00FF);
        evt_n[3] = 1'b0;
        tick(3);
        evt_n[3] = 1'b1;
        tick(10);
        check("R10 sticky after release", rdata, regval(8'hFF, 8'h08));
        write_reg(32'hFFFF_FF00);
        check("R3 status write ignored", rdata, regval(8'h00, 8'h08));
        check("R10 req held", {31'h0, smi_req}, 32'h1);
        read_reg(v);
        check("R7 read value", v, regval(8'h00, 8'h08));
        check("R7 clear keeps arm", rdata, regval(8'h00, 8'h00));

        // line held low while disarmed, then armed
        evt_n[2] = 1'b0;
        tick(5);
        check("R5 disarmed fall", rdata, 32'h0);
        write_reg(32'h0000_00FF);
        tick(6);
        check("R6 held low no event", rdata, regval(8'hFF, 8'h00));
        evt_n[2] = 1'b1;
        tick(4);

        // event detected in the clearing cycle
        evt_n[0] = 1'b0;
        tick(3);
        evt_n[1] = 1'b0;
        tick(2);
        read_reg(v);
        check("R8 read shows older flag", v, regval(8'hFF, 8'h01));
        check("R8 racing event kept", rdata, regval(8'hFF, 8'h02));
        check("R9 req after race", {30'h0, smi_req, smi_sum}, 32'h3);
        read_reg(v);
        check("R7 final clear", rdata, regval(8'hFF, 8'h00));
        evt_n = '1;
        tick(4);

        // reset mid-operation
        evt_n[7] = 1'b0;
        tick(3);
        rst_n = 1'b0;
        tick(1);
        rst_n = 1'b1;
        tick(1);
        check("R1 reset clears flags and arm", rdata, 32'h0);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule